// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block holds a running calendar clock in packed BCD, together with the byte-wide register file through which a host sets and reads it. Eight byte registers sit at consecutive addresses from the base: control, seconds, minutes, hours, weekday with century flag, day of month, month and two-digit year. The host writes with a one-cycle write strobe. A read strobe latches the addressed byte, which is presented on the read data port one clock later.

Every time field is checked before it is stored. Out-of-range values and nibbles above 9 are dropped one field at a time, so the stored fields are always legal BCD. Bit 7 of the seconds register is an oscillator halt flag: while it is set, the one-second tick input is ignored. A one-cycle `secTick` pulse advances the calendar. The seconds carry through to minutes, hours, weekday, day of month, month and year. Month lengths are correct, and February has 29 days when the year is divisible by 4. The current fields are also driven out as ports for neighbouring logic, along with a binary full year formed from a base-year parameter.

Top module: `tk_clock_regs`

## Requirements
- R1: Address map 0..7 is control, seconds, minutes, hours, weekday/century, date, month, year. A read strobe returns the addressed byte on `busRdData` one clock later. After reset the bytes read 0x90, 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00.
- R2: A control write stores (data AND 0x5F) OR 0x90, so bits 7 and 4 read as 1 and bit 5 reads as 0.
- R3: A minutes write, and the time part of a seconds write, use data bits 6:0. The field is updated only when those bits are valid BCD from 00 to 59; otherwise it keeps its value.
- R4: An hours write uses bits 5:0. It is stored only when those bits are valid BCD from 00 to 23.
- R5: Every seconds write stores data bit 7 as the halt flag, even when the seconds value is rejected. While the halt flag is 1, ticks change no field. After it is cleared, counting resumes from the held value.
- R6: A seconds read returns the halt flag in bit 7 and the BCD seconds in bits 6:0.
- R7: A weekday write stores bits 2:0 as the weekday and bit 6 as the century flag. A read returns century<<6 OR weekday, with all other bits 0.
- R8: A date write uses bits 5:0 and needs valid BCD 01–31. A month write uses bits 4:0 and needs 01–12. A year write uses the whole byte and needs 00–99. Anything else is ignored.
- R9: A tick with the halt flag clear adds one second. Seconds 59 wraps to 00 and carries to minutes. Minutes 59 wraps and carries to hours. Hours 23 wraps to 00 and carries to the day.
- R10: A day carry moves weekday 7 to 1 and any other weekday up by one. A date at or past the month length goes to 01 with a month carry. Month 12 goes to 01 with a year carry. Year 99 goes to 00.
- R11: April, June, September and November have 30 days, and the other months other than February have 31. February has 29 days when the two-digit year is divisible by 4, else 28.
- R12: `outFullYear` equals BASE_YEAR plus the decimal value of the stored year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register index |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8 | Read data, valid the cycle after busRd |
| secTick | input | 1 | One-second advance pulse |
| outSec | output | 7 | BCD seconds |
| outMin | output | 7 | BCD minutes |
| outHour | output | 6 | BCD hours |
| outWeekday | output | 3 | Weekday |
| outDate | output | 6 | BCD day of month |
| outMonth | output | 5 | BCD month |
| outYear | output | 8 | BCD two-digit year |
| outCentury | output | 1 | Century flag |
| outStopped | output | 1 | Halt flag |
| outFullYear | output | YEAR_W | Binary base year plus year |

## Verification
The assertions check the following on every cycle: seconds, hours, month and date stay legal BCD within range; a control read always shows its forced bits; time is frozen while halted; and nothing moves without a write or a tick. Only the bench scenarios can show the following: that a given illegal write left the old value in place, that the carries land on the right month and leap-year boundaries, and that the weekday wraps. For these the bench compares full readbacks against a decimal reference model.

// File: rtl/tk_pkg.sv
package tk_pkg;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_SEC   = 3'd1,
    REG_MIN   = 3'd2,
    REG_HOUR  = 3'd3,
    REG_DAY   = 3'd4,
    REG_DATE  = 3'd5,
    REG_MONTH = 3'd6,
    REG_YEAR  = 3'd7
  } tkReg_e;

  localparam int NUM_REGS = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrCtrl;
    logic       wrSecVal;
    logic       wrStop;
    logic       wrMin;
    logic       wrHour;
    logic       wrDay;
    logic       wrDate;
    logic       wrMonth;
    logic       wrYear;
    logic       rdEn;
    tkReg_e     rdSel;
    logic [7:0] wdata;
  } tkStrobes_t;

  function automatic logic bcdInRange(input logic [7:0] v, input logic [7:0] lo,
                                      input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // BCD month length; the leap test uses year mod 4 = (2*tens + ones) mod 4
  function automatic logic [7:0] monthLen(input logic [7:0] mon, input logic [7:0] yr);
    logic [1:0] yMod4;
    yMod4 = {yr[4], 1'b0} + yr[1:0];
    case (mon)
      8'h02: return (yMod4 == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/tk_ctrl.sv
module tk_ctrl
  import tk_pkg::*;
(
  input  logic [2:0]  busAddr,
  input  logic [7:0]  busWrData,
  input  logic        busWr,
  input  logic        busRd,
  output tkStrobes_t  stb
);

  tkReg_e regSel;
  logic [7:0] secField, minField, hourField, dateField, monField;

  assign regSel    = tkReg_e'(busAddr);
  assign secField  = {1'b0, busWrData[6:0]};
  assign minField  = {1'b0, busWrData[6:0]};
  assign hourField = {2'b00, busWrData[5:0]};
  assign dateField = {2'b00, busWrData[5:0]};
  assign monField  = {3'b000, busWrData[4:0]};

  always_comb begin
    stb          = '0;
    stb.wdata    = busWrData;
    stb.rdEn     = busRd;
    stb.rdSel    = regSel;
    if (busWr) begin
      case (regSel)
        REG_CTRL:  stb.wrCtrl   = 1'b1;
        REG_SEC: begin
          stb.wrStop   = 1'b1;
          stb.wrSecVal = bcdInRange(secField, 8'h00, 8'h59);
        end
        REG_MIN:   stb.wrMin    = bcdInRange(minField, 8'h00, 8'h59);
        REG_HOUR:  stb.wrHour   = bcdInRange(hourField, 8'h00, 8'h23);
        REG_DAY:   stb.wrDay    = 1'b1;
        REG_DATE:  stb.wrDate   = bcdInRange(dateField, 8'h01, 8'h31);
        REG_MONTH: stb.wrMonth  = bcdInRange(monField, 8'h01, 8'h12);
        REG_YEAR:  stb.wrYear   = bcdInRange(busWrData, 8'h00, 8'h99);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tk_datapath.sv
module tk_datapath
  import tk_pkg::*;
#(
  parameter int BASE_YEAR = 2000,
  parameter int YEAR_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tkStrobes_t        stb,
  input  logic              secTick,
  output logic [7:0]        rdData,
  output logic [6:0]        outSec,
  output logic [6:0]        outMin,
  output logic [5:0]        outHour,
  output logic [2:0]        outWeekday,
  output logic [5:0]        outDate,
  output logic [4:0]        outMonth,
  output logic [7:0]        outYear,
  output logic              outCentury,
  output logic              outStopped,
  output logic [YEAR_W-1:0] outFullYear
);

  localparam logic [7:0] CTRL_RST = 8'h90;

  logic [7:0] ctrlR, secR, minR, hourR, dateR, monR, yearR, rdR;
  logic [2:0] wdayR;
  logic       centR, stopR;

  logic [7:0] secN, minN, hourN, dateN, monN, yearN;
  logic [2:0] wdayN;
  logic       advance;

  assign advance = secTick && !stopR;

  always_comb begin
    secN  = secR;  minN = minR;  hourN = hourR;
    wdayN = wdayR; dateN = dateR; monN = monR; yearN = yearR;
    if (advance) begin
      if (secR == 8'h59) begin
        secN = 8'h00;
        if (minR == 8'h59) begin
          minN = 8'h00;
          if (hourR == 8'h23) begin
            hourN = 8'h00;
            wdayN = (wdayR == 3'd7) ? 3'd1 : wdayR + 3'd1;
            if (dateR >= monthLen(monR, yearR)) begin
              dateN = 8'h01;
              if (monR == 8'h12) begin
                monN  = 8'h01;
                yearN = (yearR == 8'h99) ? 8'h00 : bcdInc(yearR);
              end else begin
                monN = bcdInc(monR);
              end
            end else begin
              dateN = bcdInc(dateR);
            end
          end else begin
            hourN = bcdInc(hourR);
          end
        end else begin
          minN = bcdInc(minR);
        end
      end else begin
        secN = bcdInc(secR);
      end
    end
    // host writes take the field over the advanced value
    if (stb.wrSecVal) secN  = {1'b0, stb.wdata[6:0]};
    if (stb.wrMin)    minN  = {1'b0, stb.wdata[6:0]};
    if (stb.wrHour)   hourN = {2'b00, stb.wdata[5:0]};
    if (stb.wrDay)    wdayN = stb.wdata[2:0];
    if (stb.wrDate)   dateN = {2'b00, stb.wdata[5:0]};
    if (stb.wrMonth)  monN  = {3'b000, stb.wdata[4:0]};
    if (stb.wrYear)   yearN = stb.wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlR <= CTRL_RST;
      secR  <= 8'h00; minR <= 8'h00; hourR <= 8'h00;
      wdayR <= 3'd1;  dateR <= 8'h01; monR <= 8'h01; yearR <= 8'h00;
      centR <= 1'b0;  stopR <= 1'b0;
    end else begin
      secR  <= secN;  minR <= minN;  hourR <= hourN;
      wdayR <= wdayN; dateR <= dateN; monR <= monN; yearR <= yearN;
      if (stb.wrCtrl) ctrlR <= (stb.wdata & 8'h5F) | 8'h90;
      if (stb.wrStop) stopR <= stb.wdata[7];
      if (stb.wrDay)  centR <= stb.wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdR <= 8'h00;
    end else if (stb.rdEn) begin
      case (stb.rdSel)
        REG_CTRL:  rdR <= ctrlR;
        REG_SEC:   rdR <= {stopR, secR[6:0]};
        REG_MIN:   rdR <= minR;
        REG_HOUR:  rdR <= hourR;
        REG_DAY:   rdR <= {1'b0, centR, 3'b000, wdayR};
        REG_DATE:  rdR <= dateR;
        REG_MONTH: rdR <= monR;
        default:   rdR <= yearR;
      endcase
    end
  end

  assign rdData      = rdR;
  assign outSec      = secR[6:0];
  assign outMin      = minR[6:0];
  assign outHour     = hourR[5:0];
  assign outWeekday  = wdayR;
  assign outDate     = dateR[5:0];
  assign outMonth    = monR[4:0];
  assign outYear     = yearR;
  assign outCentury  = centR;
  assign outStopped  = stopR;
  assign outFullYear = YEAR_W'(BASE_YEAR) + YEAR_W'(yearR[7:4]) * YEAR_W'(10)
                     + YEAR_W'(yearR[3:0]);

endmodule

// File: rtl/tk_clock_regs.sv
module tk_clock_regs
  import tk_pkg::*;
#(
  parameter int BASE_YEAR = 2000,
  parameter int YEAR_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [7:0]        busRdData,
  input  logic              secTick,
  output logic [6:0]        outSec,
  output logic [6:0]        outMin,
  output logic [5:0]        outHour,
  output logic [2:0]        outWeekday,
  output logic [5:0]        outDate,
  output logic [4:0]        outMonth,
  output logic [7:0]        outYear,
  output logic              outCentury,
  output logic              outStopped,
  output logic [YEAR_W-1:0] outFullYear
);

  tkStrobes_t stb;

  tk_ctrl u_ctrl (
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWr     (busWr),
    .busRd     (busRd),
    .stb       (stb)
  );

  tk_datapath #(.BASE_YEAR(BASE_YEAR), .YEAR_W(YEAR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .secTick     (secTick),
    .rdData      (busRdData),
    .outSec      (outSec),
    .outMin      (outMin),
    .outHour     (outHour),
    .outWeekday  (outWeekday),
    .outDate     (outDate),
    .outMonth    (outMonth),
    .outYear     (outYear),
    .outCentury  (outCentury),
    .outStopped  (outStopped),
    .outFullYear (outFullYear)
  );

endmodule

// File: rtl/tk_clock_checker.sv
module tk_clock_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] busAddr,
  input logic       busWr,
  input logic       busRd,
  input logic [7:0] busRdData,
  input logic       secTick,
  input logic [6:0] outSec,
  input logic [6:0] outMin,
  input logic [5:0] outHour,
  input logic [5:0] outDate,
  input logic [4:0] outMonth,
  input logic       outStopped
);

  assert_ctrl_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 3'd0) |=> (busRdData[7] && busRdData[4] && !busRdData[5]));

  assert_sec_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outSec[3:0] <= 4'd9) && (outSec[6:4] <= 3'd5));

  assert_hour_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outHour[3:0] <= 4'd9) && (outHour <= 6'h23));

  assert_halt_freeze_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outStopped && !busWr) |=> $stable(outSec) && $stable(outMin) && $stable(outHour));

  assert_month_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outMonth >= 5'h01) && (outMonth <= 5'h12) && (outMonth[3:0] <= 4'd9));

  assert_date_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outDate >= 6'h01) && (outDate <= 6'h31) && (outDate[3:0] <= 4'd9));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busWr && !secTick) |=> $stable(outSec) && $stable(outMin) && $stable(outHour)
                            && $stable(outDate) && $stable(outMonth));

endmodule

bind tk_clock_regs tk_clock_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWr      (busWr),
  .busRd      (busRd),
  .busRdData  (busRdData),
  .secTick    (secTick),
  .outSec     (outSec),
  .outMin     (outMin),
  .outHour    (outHour),
  .outDate    (outDate),
  .outMonth   (outMonth),
  .outStopped (outStopped)
);

// File: tb/sim_tk_clock_regs.sv
module sim_tk_clock_regs;

  localparam int CLK_PERIOD = 10;
  localparam int BASE_YEAR  = 2000;
  localparam int YEAR_W     = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busWr = 1'b0, busRd = 1'b0, secTick = 1'b0;
  logic [7:0] busRdData;
  logic [6:0] outSec, outMin;
  logic [5:0] outHour, outDate;
  logic [2:0] outWeekday;
  logic [4:0] outMonth;
  logic [7:0] outYear;
  logic outCentury, outStopped;
  logic [YEAR_W-1:0] outFullYear;

  int checks = 0, failures = 0;
  bit done = 0;

  // decimal reference model
  int ms = 0, mm = 0, mh = 0, mwd = 1, md = 1, mmo = 1, my = 0, mcent = 0, mstop = 0;
  int mctrl = 'h90;

  always #(CLK_PERIOD/2) clk = ~clk;

  tk_clock_regs #(.BASE_YEAR(BASE_YEAR), .YEAR_W(YEAR_W)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData), .busWr(busWr),
    .busRd(busRd), .busRdData(busRdData), .secTick(secTick), .outSec(outSec),
    .outMin(outMin), .outHour(outHour), .outWeekday(outWeekday), .outDate(outDate),
    .outMonth(outMonth), .outYear(outYear), .outCentury(outCentury),
    .outStopped(outStopped), .outFullYear(outFullYear)
  );

  function automatic int toBcd(int x);
    return ((x / 10) << 4) | (x % 10);
  endfunction

  function automatic int decOf(int v, int lo, int hi);
    int t, o, x;
    t = (v >> 4) & 15; o = v & 15;
    if (t > 9 || o > 9) return -1;
    x = t * 10 + o;
    if (x < lo || x > hi) return -1;
    return x;
  endfunction

  function automatic int daysIn(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic void modelWrite(int a, int d);
    int x;
    case (a)
      0: mctrl = (d & 'h5F) | 'h90;
      1: begin x = decOf(d & 'h7F, 0, 59); if (x >= 0) ms = x; mstop = (d >> 7) & 1; end
      2: begin x = decOf(d & 'h7F, 0, 59); if (x >= 0) mm = x; end
      3: begin x = decOf(d & 'h3F, 0, 23); if (x >= 0) mh = x; end
      4: begin mwd = d & 7; mcent = (d >> 6) & 1; end
      5: begin x = decOf(d & 'h3F, 1, 31); if (x >= 0) md = x; end
      6: begin x = decOf(d & 'h1F, 1, 12); if (x >= 0) mmo = x; end
      default: begin x = decOf(d & 'hFF, 0, 99); if (x >= 0) my = x; end
    endcase
  endfunction

  function automatic void modelTick();
    if (mstop) return;
    ms++;
    if (ms < 60) return;
    ms = 0; mm++;
    if (mm < 60) return;
    mm = 0; mh++;
    if (mh < 24) return;
    mh = 0;
    mwd = (mwd == 7) ? 1 : mwd + 1;
    if (md >= daysIn(mmo, my)) begin
      md = 1; mmo++;
      if (mmo > 12) begin mmo = 1; my = (my + 1) % 100; end
    end else md++;
  endfunction

  function automatic int expRead(int a);
    case (a)
      0: return mctrl;
      1: return (mstop << 7) | toBcd(ms);
      2: return toBcd(mm);
      3: return toBcd(mh);
      4: return (mcent << 6) | mwd;
      5: return toBcd(md);
      6: return toBcd(mmo);
      default: return toBcd(my);
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input int a, input int d);
    @(negedge clk);
    busAddr = 3'(a); busWrData = 8'(d); busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic doRead(input int a, output int v);
    @(negedge clk);
    busAddr = 3'(a); busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    v = int'(busRdData);
  endtask

  task automatic doTick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    modelTick();
  endtask

  task automatic compareAll(input string tag);
    int v;
    string nm [8];
    nm = '{"R2 ctrl", "R6 sec", "R3 min", "R4 hour", "R7 day", "R8 date", "R8 month", "R8 year"};
    for (int a = 0; a < 8; a++) begin
      doRead(a, v);
      chk({tag, " ", nm[a]}, v, expRead(a));
    end
    chk({tag, " R9 port sec"}, int'(outSec), toBcd(ms));
    chk({tag, " R10 port weekday"}, int'(outWeekday), mwd);
    chk({tag, " R12 full year"}, int'(outFullYear), BASE_YEAR + my);
  endtask

  task automatic setTime(input int y, input int mo, input int d, input int h,
                         input int mi, input int s, input int wd);
    doWrite(7, y); doWrite(6, mo); doWrite(5, d); doWrite(3, h);
    doWrite(2, mi); doWrite(1, s); doWrite(4, wd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seedInit, op, a, d, v;
    seedInit = $urandom(32'd7919);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compareAll("R1 reset");

    // R2 control forcing
    doWrite(0, 'hFF); compareAll("R2 ctrl ff");
    doWrite(0, 'h00); compareAll("R2 ctrl 00");

    // R3 range and nibble rejection
    doWrite(1, 'h59); doWrite(1, 'h5A); doWrite(1, 'h60); doWrite(2, 'h7F);
    compareAll("R3 reject");
    doWrite(3, 'h24); doWrite(3, 'h1A); compareAll("R4 reject");
    doWrite(5, 'h00); doWrite(6, 'h13); doWrite(7, 'hA0); compareAll("R8 reject");
    doWrite(4, 'hFE); compareAll("R7 century weekday");

    // R5 halt flag
    doWrite(1, 'hB0);
    repeat (3) doTick();
    compareAll("R5 halted");
    doWrite(1, 'hFA); doTick(); compareAll("R5 halt invalid value");
    doWrite(1, 'h30); doTick(); compareAll("R5 resume");

    // R10 R11 calendar corners
    setTime('h24, 'h02, 'h28, 'h23, 'h59, 'h59, 'h07); doTick(); compareAll("R11 leap feb28");
    setTime('h24, 'h02, 'h29, 'h23, 'h59, 'h59, 'h03); doTick(); compareAll("R11 leap feb29");
    setTime('h23, 'h02, 'h28, 'h23, 'h59, 'h59, 'h02); doTick(); compareAll("R11 feb28");
    setTime('h23, 'h04, 'h30, 'h23, 'h59, 'h59, 'h05); doTick(); compareAll("R11 apr30");
    setTime('h99, 'h12, 'h31, 'h23, 'h59, 'h59, 'h07); doTick(); compareAll("R10 year wrap");
    setTime('h05, 'h07, 'h14, 'h09, 'h59, 'h58, 'h01);
    repeat (2) doTick(); compareAll("R9 minute carry");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      op = $urandom_range(0, 9);
      a = $urandom_range(0, 7);
      if ($urandom_range(0, 1) == 1) d = $urandom_range(0, 255);
      else d = toBcd($urandom_range(0, 59)) | (a == 1 ? ($urandom_range(0, 3) == 0 ? 'h80 : 0) : 0);
      if (op < 4) doWrite(a, d);
      else if (op < 8) doTick();
      else begin doRead(a, v); chk("R1 random read", v, expRead(a)); end
    end
    compareAll("R9 random end");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule